// File: doc/BRIEF.md
# Filtered Quadrature Position Counter

This block turns the two phase-shifted tracks of an incremental shaft encoder into a signed-direction position count. An index track resets the count. The raw A, B and Z inputs are brought into the clock domain first. Next come an optional exchange of the two tracks and a filter that rejects short index disturbances. The decoder counts every edge of both tracks, so each full track cycle adds or removes four counts. It rejects any clock cycle in which both tracks move at once.

The count wraps at a selectable width of 10, 12, 14 or 16 bits. Two target comparators watch the count and emit a one-cycle pulse each time the count arrives at their value. Their targets may be changed while the shaft turns. A deviation pulse flags every step that runs against the programmed direction. An active-low test input splits the counter into four independent 4-bit counters, so a short run exercises every bit of the count.

Top module: `qpos_counter`

## Requirements
- R1: While `rst_n` is low, and in the cycles after its release with the inputs idle, `position` is 0 and `hit0`, `hit1`, `dir_err` and `index_evt` are low.
- R2: With the decoded pair (A,B) stepping through the states 00, 10, 11, 01 in that order (A leads), every state change adds one to `position`. Stepping in the reverse order subtracts one. The new count appears on the third rising clock edge after the input change.
- R3: `res_sel` selects the counter width: 2'b00 gives 10 bits, 2'b10 gives 12, 2'b01 gives 14 and 2'b11 gives 16. Counting wraps modulo 2 to the power of that width, in both directions.
- R4: If the synchronised A and B change in the same cycle, the count does not change and `dir_err` does not pulse.
- R5: With `swap_ab` high, `a_in` is decoded as track B and `b_in` as track A, so a sequence that counts up unswapped counts down.
- R6: `z_in` is accepted only when it stays high for at least 4 consecutive clock samples. A shorter pulse has no effect. An accepted pulse clears `position` to 0 and gives exactly one `index_evt` pulse, however long `z_in` stays high.
- R7: When an accepted index and a valid track step land in the same cycle, the index wins and `position` becomes 0.
- R8: `hitN` pulses for one cycle whenever `position` changes to a value that equals `targetN` in the active width's bits. Bits above the width are ignored. Holding the value gives no further pulse, and reloading `targetN` never causes a pulse.
- R9: `dir_err` pulses for one cycle, in the same cycle as the count change, on each valid step that counts down while `dir_ccw` is 0, or that counts up while `dir_ccw` is 1.
- R10: While `test_n` is low, each valid step adds or subtracts one in each 4-bit field of `position` independently, with no carry between fields, and ignores `res_sel`. For example, 16'h0000 stepped down gives 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 1 | Raw encoder track A |
| b_in | input | 1 | Raw encoder track B |
| z_in | input | 1 | Raw index track |
| swap_ab | input | 1 | Exchange tracks A and B before decoding |
| dir_ccw | input | 1 | Expected direction: 0 counts up, 1 counts down |
| res_sel | input | 2 | Counter width select |
| test_n | input | 1 | Active-low split into four 4-bit counters |
| target0 | input | 16 | First target value |
| target1 | input | 16 | Second target value |
| position | output | 16 | Current count |
| hit0 | output | 1 | Arrival at target0 |
| hit1 | output | 1 | Arrival at target1 |
| dir_err | output | 1 | Step against the expected direction |
| index_evt | output | 1 | Accepted index pulse |

## Verification
The index clear and a quadrature step can fall into the same cycle. They would then compete for the count register. The bench raises `z_in` and drives a track change three falling edges later. This lines the step's three-stage latency up with the index filter's six-edge acceptance point. The bench judges the case by a count of exactly 0 after that edge, rather than 1, together with a single `index_evt` pulse.

// File: rtl/qpos_counter.sv
module qpos_counter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        a_in,
  input  logic        b_in,
  input  logic        z_in,
  input  logic        swap_ab,
  input  logic        dir_ccw,
  input  logic [1:0]  res_sel,
  input  logic        test_n,
  input  logic [15:0] target0,
  input  logic [15:0] target1,
  output logic [15:0] position,
  output logic        hit0,
  output logic        hit1,
  output logic        dir_err,
  output logic        index_evt
);
  logic [1:0]  a_sy, b_sy, z_sy;
  logic        a_d, b_d;
  logic [2:0]  zcnt;
  logic [15:0] cnt, nxt, mask, cmask, nib_nx;

  wire a_m  = swap_ab ? b_in : a_in;
  wire b_m  = swap_ab ? a_in : b_in;
  wire ea   = a_sy[1] ^ a_d;
  wire eb   = b_sy[1] ^ b_d;
  wire step = ea ^ eb;
  wire up   = ea ? (a_sy[1] != b_sy[1]) : (a_sy[1] == b_sy[1]);
  wire zfire = z_sy[1] && (zcnt == 3'd3);

  always_comb begin
    case (res_sel)
      2'b00:   mask = 16'h03FF;
      2'b10:   mask = 16'h0FFF;
      2'b01:   mask = 16'h3FFF;
      default: mask = 16'hFFFF;
    endcase
  end

  assign cmask = test_n ? mask : 16'hFFFF;

  for (genvar i = 0; i < 4; i++) begin : g_nib
    assign nib_nx[4*i +: 4] = up ? cnt[4*i +: 4] + 4'd1 : cnt[4*i +: 4] - 4'd1;
  end

  always_comb begin
    if (zfire)        nxt = '0;
    else if (!step)   nxt = cnt;
    else if (!test_n) nxt = nib_nx;
    else              nxt = (up ? cnt + 16'd1 : cnt - 16'd1) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sy <= '0; b_sy <= '0; z_sy <= '0;
      a_d <= 1'b0; b_d <= 1'b0;
      zcnt <= '0;
      cnt <= '0;
      hit0 <= 1'b0; hit1 <= 1'b0;
      dir_err <= 1'b0; index_evt <= 1'b0;
    end else begin
      a_sy <= {a_sy[0], a_m};
      b_sy <= {b_sy[0], b_m};
      z_sy <= {z_sy[0], z_in};
      a_d  <= a_sy[1];
      b_d  <= b_sy[1];
      if (!z_sy[1])           zcnt <= '0;
      else if (zcnt != 3'd4)  zcnt <= zcnt + 3'd1;
      cnt       <= nxt;
      index_evt <= zfire;
      dir_err   <= step && (up == dir_ccw);
      hit0      <= (nxt != cnt) && ((nxt & cmask) == (target0 & cmask));
      hit1      <= (nxt != cnt) && ((nxt & cmask) == (target1 & cmask));
    end
  end

  assign position = cnt;
endmodule

// File: rtl/qpos_counter_chk.sv
module qpos_counter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  res_sel,
  input logic        test_n,
  input logic [15:0] position,
  input logic        hit0,
  input logic        hit1,
  input logic        dir_err,
  input logic        index_evt
);
  logic [15:0] m;
  always_comb begin
    case (res_sel)
      2'b00:   m = 16'h03FF;
      2'b10:   m = 16'h0FFF;
      2'b01:   m = 16'h3FFF;
      default: m = 16'hFFFF;
    endcase
  end

  AST_INDEX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) index_evt |-> position == 16'h0); // R6
  AST_INDEX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) index_evt |=> !index_evt); // R6
  AST_STEP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (test_n && $past(test_n) && $stable(res_sel) && !index_evt) |->
    (((position - $past(position)) & m) == 16'h0 || ((position - $past(position)) & m) == 16'h1 ||
     ((position - $past(position)) & m) == m)); // R3
  AST_HIT0_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n) hit0 |-> position != $past(position)); // R8
  AST_HIT1_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n) hit1 |-> position != $past(position)); // R8
  AST_DIR_WITH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_err && !index_evt) |-> position != $past(position)); // R9
endmodule

bind qpos_counter qpos_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .res_sel(res_sel), .test_n(test_n),
  .position(position), .hit0(hit0), .hit1(hit1), .dir_err(dir_err), .index_evt(index_evt)
);

// File: tb/sim_qpos_counter.sv
module sim_qpos_counter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_in = 0, b_in = 0, z_in = 0, swap_ab = 0, dir_ccw = 0, test_n = 1;
  logic [1:0] res_sel = 2'b11;
  logic [15:0] target0 = 16'hFFFF, target1 = 16'hFFFF;
  logic [15:0] position;
  logic hit0, hit1, dir_err, index_evt;

  int errors = 0, checks = 0;
  int n_hit0 = 0, n_hit1 = 0, n_dir = 0, n_idx = 0;
  int st = 0;
  int exp_pos = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qpos_counter u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .z_in(z_in),
    .swap_ab(swap_ab), .dir_ccw(dir_ccw), .res_sel(res_sel), .test_n(test_n),
    .target0(target0), .target1(target1), .position(position),
    .hit0(hit0), .hit1(hit1), .dir_err(dir_err), .index_evt(index_evt)
  );

  always @(negedge clk) if (rst_n) begin
    n_hit0 <= n_hit0 + int'(hit0);
    n_hit1 <= n_hit1 + int'(hit1);
    n_dir  <= n_dir + int'(dir_err);
    n_idx  <= n_idx + int'(index_evt);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic put(input int s);
    a_in = (s == 1) || (s == 2);
    b_in = (s == 2) || (s == 3);
  endtask

  task automatic step(input bit up);
    st = up ? (st + 1) % 4 : (st + 3) % 4;
    put(st);
    tick(4);
  endtask

  task automatic zpulse(input int n);
    z_in = 1'b1; tick(n); z_in = 1'b0; tick(6);
  endtask

  function automatic int wmask(input logic [1:0] r);
    case (r)
      2'b00: return 'h3FF;
      2'b10: return 'hFFF;
      2'b01: return 'h3FFF;
      default: return 'hFFFF;
    endcase
  endfunction

  initial begin
    int d0, i0, h0, h1;
    tick(3);
    chk("R1 reset position", int'(position), 0);
    chk("R1 reset pulses", int'({hit0, hit1, dir_err, index_evt}), 0);
    rst_n = 1'b1;
    tick(5);
    chk("R1 idle position", int'(position), 0);
    chk("R1 idle pulses", n_hit0 + n_hit1 + n_dir + n_idx, 0);

    // R2/R3: full up sweep across the 10-bit wrap
    res_sel = 2'b00;
    exp_pos = 0;
    for (int k = 0; k < 1030; k++) begin
      step(1);
      exp_pos = (exp_pos + 1) & 'h3FF;
      chk("R2 up sweep", int'(position), exp_pos);
    end
    chk("R9 no deviation while counting up", n_dir, 0);
    for (int k = 0; k < 8; k++) begin
      d0 = n_dir;
      step(0);
      exp_pos = (exp_pos - 1) & 'h3FF;
      chk("R2 down step", int'(position), exp_pos);
      chk("R9 deviation on down step", n_dir - d0, 1);
    end

    // R3: wrap at each width
    for (int r = 0; r < 4; r++) begin
      res_sel = 2'(r);
      zpulse(4);
      chk("R6 index clears", int'(position), 0);
      step(0);
      chk("R3 wrap down", int'(position), wmask(res_sel));
      step(1);
      chk("R3 wrap up", int'(position), 0);
    end

    // R4: both tracks change together
    res_sel = 2'b11;
    step(1); step(1);
    d0 = n_dir;
    st = (st + 2) % 4; put(st); tick(5);
    chk("R4 double change ignored", int'(position), 2);
    chk("R4 no deviation", n_dir - d0, 0);
    step(1);
    chk("R4 decoding resumes", int'(position), 3);

    // R5: exchanged tracks
    while (st != 0) step(1);
    exp_pos = int'(position);
    swap_ab = 1'b1; tick(5);
    chk("R5 swap at equal tracks", int'(position), exp_pos);
    for (int k = 1; k <= 3; k++) begin
      step(1);
      chk("R5 swapped counts down", int'(position), (exp_pos - k) & 'hFFFF);
    end
    for (int k = 0; k < 3; k++) step(0);
    chk("R5 swapped return", int'(position), exp_pos);
    swap_ab = 1'b0; tick(5);

    // R6: index filter
    i0 = n_idx;
    zpulse(3);
    chk("R6 short index rejected", int'(position), exp_pos);
    chk("R6 no index event", n_idx - i0, 0);
    zpulse(12);
    chk("R6 long index clears", int'(position), 0);
    chk("R6 one event per pulse", n_idx - i0, 1);

    // R7: index and step in the same cycle
    step(1); step(1); step(1);
    i0 = n_idx;
    z_in = 1'b1; tick(3);
    st = (st + 1) % 4; put(st);
    tick(5); z_in = 1'b0; tick(5);
    chk("R7 index wins over step", int'(position), 0);
    chk("R7 single index event", n_idx - i0, 1);

    // R8: target comparators
    res_sel = 2'b00;
    target0 = 16'hFC05; target1 = 16'h0003;
    h0 = n_hit0; h1 = n_hit1;
    for (int k = 0; k < 5; k++) step(1);
    chk("R8 target0 upper bits ignored", n_hit0 - h0, 1);
    chk("R8 target1 passed once", n_hit1 - h1, 1);
    step(1); step(0);
    chk("R8 second arrival", n_hit0 - h0, 2);
    tick(10);
    chk("R8 holding gives no pulse", n_hit0 - h0, 2);
    target1 = 16'h0005; tick(5);
    chk("R8 reload gives no pulse", n_hit1 - h1, 1);
    step(1); step(0);
    chk("R8 reloaded target hit", n_hit1 - h1, 2);

    // R9: reversed expected direction
    dir_ccw = 1'b1;
    d0 = n_dir;
    step(1);
    chk("R9 up against ccw", n_dir - d0, 1);
    step(0);
    chk("R9 down with ccw", n_dir - d0, 1);
    dir_ccw = 1'b0;

    // R10: split test mode
    zpulse(4);
    test_n = 1'b0;
    for (int k = 1; k <= 16; k++) begin
      step(1);
      chk("R10 nibbles up", int'(position), (k % 16) * 'h1111);
    end
    step(0);
    chk("R10 nibbles down wrap", int'(position), 'hFFFF);
    step(1);
    chk("R10 nibbles back", int'(position), 0);
    test_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule